// File: doc/BRIEF.md
# General-Purpose I/O Port with Strobed Capture and Line Interrupts

This block is a 32-line general-purpose I/O port. A small register interface configures it. Each line can be set to drive a value onto its pad, to be read as an input, or to stay in high impedance. Input lines are captured into a register. The capture can follow the system clock on either of its edges, or it can follow an external strobe input on the edge that software selects.

Each input line can be armed to raise an interrupt. When a capture changes the value of an armed input line, that line's flag sets and stays set. Software clears a flag by writing a one to its bit. The interrupt output is high whenever an armed line has its flag set.

Pad drive and enable leave the block as separate buses. The tri-state buffer itself sits in the pad ring.

Top module: `gpio_port`

## Requirements
- R1: After reset the register values are: drive enable 0x00000000, input enable 0xFFFFFFFF, output value 0, interrupt enable 0, flags 0, capture config 0 and captured value 0. `pin_oe_o` and `irq_o` are both 0.
- R2: The register map is 0 drive enable, 1 input enable, 2 output value, 3 captured value, 4 interrupt enable, 5 interrupt flags and 6 capture config. The capture config uses bit 0 for the source (1 = strobe) and bit 1 for the edge (1 = falling); its other bits read 0. The written registers read back what was last written. A write to address 3 has no effect. Address 7 reads 0.
- R3: `pin_oe_o` and `pin_out_o` take the values written to the drive-enable and output-value registers on the clock edge that performs the write.
- R4: A line counts as an input when its input-enable bit is 1 and its drive-enable bit is 0. A capture updates only input lines; every other line holds its captured bit.
- R5: With the clock as the source, a capture takes place on every cycle. For the rising edge, a pad change appears in the captured register at the third rising clock edge. For the falling edge, the pad is sampled on the falling clock edge, and the value appears at the second rising edge after that sample.
- R6: With the strobe as the source and the rising edge selected, the strobe passes through a two-flop synchronizer. Each strobe rising edge causes exactly one capture, at the third clock edge after the strobe changes. Pad changes with no strobe edge, and strobe falling edges, leave the captured register unchanged.
- R7: With the strobe as the source and the falling edge selected, captures occur only on strobe falling edges. Strobe rising edges are ignored.
- R8: A flag bit sets when a capture changes the captured bit of a line whose interrupt-enable bit is 1. Lines whose interrupt-enable bit is 0 never set a flag.
- R9: Flags are sticky. Writing 1 to a bit of address 5 clears that bit; bits written as 0 are unchanged. If a set and a clear of the same bit fall on the same clock edge, the set wins.
- R10: `irq_o` is the OR over all lines of flag AND interrupt enable. Clearing an enable masks the interrupt but keeps the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronized |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register address for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| pin_in_i | input | 32 | Pad input levels |
| pin_out_o | output | 32 | Pad output levels |
| pin_oe_o | output | 32 | Pad drive enables, 1 = drive |
| strobe_i | input | 1 | External capture strobe, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on two things about the inputs. First, pad data is stable around the strobe edge that captures it, so a strobe capture sees a settled value. Second, the strobe stays at each level for longer than the synchronizer depth, so that no edge is lost. The stimulus changes pad values only while the strobe is idle, and it holds each strobe level for at least four cycles. All inputs change a quarter period after a rising edge. This keeps them clear of both the rising-edge and the falling-edge samplers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DRV_EN  = 3'd0,
    A_IN_EN   = 3'd1,
    A_OUT_VAL = 3'd2,
    A_CAPT    = 3'd3,
    A_IRQ_EN  = 3'd4,
    A_IRQ_FLG = 3'd5,
    A_CFG     = 3'd6,
    A_RSVD    = 3'd7
  } reg_addr_e;

  // bit 1: falling edge, bit 0: strobe source
  typedef struct packed {
    logic falling;
    logic use_strobe;
  } cap_cfg_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      captured_i,
  input  logic [N-1:0]      flags_i,
  output logic [N-1:0]      drv_en_o,
  output logic [N-1:0]      in_en_o,
  output logic [N-1:0]      out_val_o,
  output logic [N-1:0]      irq_en_o,
  output cap_cfg_t          cfg_o,
  output logic [N-1:0]      flag_clr_o,
  output logic [N-1:0]      rdata_o
);
  logic [N-1:0] drv_en_q, drv_en_d;
  logic [N-1:0] in_en_q, in_en_d;
  logic [N-1:0] out_val_q, out_val_d;
  logic [N-1:0] irq_en_q, irq_en_d;
  cap_cfg_t     cfg_q, cfg_d;
  reg_addr_e    addr;

  assign addr = reg_addr_e'(addr_i);

  always_comb begin
    drv_en_d  = drv_en_q;
    in_en_d   = in_en_q;
    out_val_d = out_val_q;
    irq_en_d  = irq_en_q;
    cfg_d     = cfg_q;
    if (wr_i) begin
      unique case (addr)
        A_DRV_EN:  drv_en_d  = wdata_i;
        A_IN_EN:   in_en_d   = wdata_i;
        A_OUT_VAL: out_val_d = wdata_i;
        A_IRQ_EN:  irq_en_d  = wdata_i;
        A_CFG:     cfg_d     = cap_cfg_t'(wdata_i[1:0]);
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_en_q  <= '0;
      in_en_q   <= '1;
      out_val_q <= '0;
      irq_en_q  <= '0;
      cfg_q     <= '0;
    end else begin
      drv_en_q  <= drv_en_d;
      in_en_q   <= in_en_d;
      out_val_q <= out_val_d;
      irq_en_q  <= irq_en_d;
      cfg_q     <= cfg_d;
    end
  end

  assign flag_clr_o = (wr_i && addr == A_IRQ_FLG) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_DRV_EN:  rdata_o = drv_en_q;
      A_IN_EN:   rdata_o = in_en_q;
      A_OUT_VAL: rdata_o = out_val_q;
      A_CAPT:    rdata_o = captured_i;
      A_IRQ_EN:  rdata_o = irq_en_q;
      A_IRQ_FLG: rdata_o = flags_i;
      A_CFG:     rdata_o[1:0] = cfg_q;
      default:   rdata_o = '0;
    endcase
  end

  assign drv_en_o  = drv_en_q;
  assign in_en_o   = in_en_q;
  assign out_val_o = out_val_q;
  assign irq_en_o  = irq_en_q;
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture
  import gpio_port_pkg::*;
#(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic         strobe_i,
  input  cap_cfg_t     cfg_i,
  input  logic [N-1:0] in_mask_i,
  output logic [N-1:0] captured_o,
  output logic         cap_en_o,
  output logic [N-1:0] changed_o
);
  logic [N-1:0]           samp_rise_q, samp_fall_q, stage_q, stage_d;
  logic [N-1:0]           cap_q, cap_d;
  logic [SYNC_STAGES-1:0] stb_q, stb_d;
  logic                   stb_prev_q;
  logic                   stb_rise, stb_fall, cap_en;

  // pad sampling on both clock edges; the falling one only feeds clock-falling mode
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) samp_fall_q <= '0;
    else         samp_fall_q <= pin_i;
  end

  always_comb begin
    stage_d = (!cfg_i.use_strobe && cfg_i.falling) ? samp_fall_q : samp_rise_q;
    stb_d   = {stb_q[SYNC_STAGES-2:0], strobe_i};
  end

  assign stb_rise = stb_q[SYNC_STAGES-1] & ~stb_prev_q;
  assign stb_fall = ~stb_q[SYNC_STAGES-1] & stb_prev_q;

  always_comb begin
    if (cfg_i.use_strobe) cap_en = cfg_i.falling ? stb_fall : stb_rise;
    else                  cap_en = 1'b1;
    cap_d = cap_en ? ((stage_q & in_mask_i) | (cap_q & ~in_mask_i)) : cap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_rise_q <= '0;
      stage_q     <= '0;
      stb_q       <= '0;
      stb_prev_q  <= 1'b0;
      cap_q       <= '0;
    end else begin
      samp_rise_q <= pin_i;
      stage_q     <= stage_d;
      stb_q       <= stb_d;
      stb_prev_q  <= stb_q[SYNC_STAGES-1];
      cap_q       <= cap_d;
    end
  end

  assign captured_o = cap_q;
  assign cap_en_o   = cap_en;
  assign changed_o  = cap_d ^ cap_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] changed_i,
  input  logic [N-1:0] irq_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, flag_d;

  // a set on the same edge as a clear wins
  always_comb begin
    flag_d = (flag_q & ~clr_i) | (changed_i & irq_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & irq_en_i);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int N           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N-1:0]      reg_wdata_i,
  output logic [N-1:0]      reg_rdata_o,
  input  logic [N-1:0]      pin_in_i,
  output logic [N-1:0]      pin_out_o,
  output logic [N-1:0]      pin_oe_o,
  input  logic              strobe_i,
  output logic              irq_o
);
  logic         rst_n;
  logic [N-1:0] drv_en, in_en, out_val, irq_en, flag_clr;
  logic [N-1:0] captured, changed, flags, in_mask;
  logic         cap_en;
  cap_cfg_t     cfg;

  gpio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  gpio_regs #(.N(N)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .captured_i(captured), .flags_i(flags),
    .drv_en_o(drv_en), .in_en_o(in_en), .out_val_o(out_val),
    .irq_en_o(irq_en), .cfg_o(cfg), .flag_clr_o(flag_clr), .rdata_o(reg_rdata_o)
  );

  assign in_mask = in_en & ~drv_en;

  gpio_capture #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_n), .pin_i(pin_in_i), .strobe_i(strobe_i),
    .cfg_i(cfg), .in_mask_i(in_mask), .captured_o(captured),
    .cap_en_o(cap_en), .changed_o(changed)
  );

  gpio_irq #(.N(N)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_n), .changed_i(changed), .irq_en_i(irq_en),
    .clr_i(flag_clr), .flags_o(flags), .irq_o(irq_o)
  );

  assign pin_out_o = out_val;
  assign pin_oe_o  = drv_en;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rst_n,
  input logic         reg_wr_i,
  input logic [2:0]   reg_addr_i,
  input logic [N-1:0] reg_wdata_i,
  input logic [N-1:0] pin_out_o,
  input logic [N-1:0] pin_oe_o,
  input logic         irq_o,
  input logic [N-1:0] irq_en,
  input logic [N-1:0] flags,
  input logic [N-1:0] captured,
  input logic         cap_en,
  input logic         use_strobe
);
  p_drive_enable_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    (reg_wr_i && reg_addr_i == 3'd0) |=> pin_oe_o == $past(reg_wdata_i));

  p_output_value_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    (reg_wr_i && reg_addr_i == 3'd2) |=> pin_out_o == $past(reg_wdata_i));

  p_capture_holds_without_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    (use_strobe && !cap_en) |=> captured == $past(captured));

  p_single_capture_per_strobe_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    (use_strobe && cap_en) |=> (!cap_en || !use_strobe));

  p_no_flag_on_disabled_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(irq_en)) == '0));

  p_irq_needs_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    (irq_en == '0) |-> !irq_o);

  p_irq_from_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_n)
    irq_o |-> (flags != '0));
endmodule

bind gpio_port gpio_port_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rst_n(rst_n), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .pin_out_o(pin_out_o),
  .pin_oe_o(pin_oe_o), .irq_o(irq_o), .irq_en(irq_en), .flags(flags),
  .captured(captured), .cap_en(cap_en), .use_strobe(cfg.use_strobe)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reg_wr_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i, reg_rdata_o, pin_in_i, pin_out_o, pin_oe_o;
  logic        strobe_i, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gpio_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .strobe_i(strobe_i), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [31:0] pins;
    logic [31:0] cap;
    logic [31:0] flg;
  } vec_t;

  // clock rising mode, lines 8..15 driven, interrupts armed on lines 0..7
  localparam vec_t VECS [6] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0001},
    '{32'h0000_FF01, 32'h0000_0001, 32'h0000_0000},
    '{32'h8000_0081, 32'h8000_0081, 32'h0000_0080},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0081},
    '{32'h5555_AAAA, 32'h5555_00AA, 32'h0000_00AA},
    '{32'hFFFF_FFFF, 32'hFFFF_00FF, 32'h0000_0055}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #5;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #5;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_ni = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    pin_in_i = '0; strobe_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    tick(3);

    // R1 reset state
    rd(3'd0, v); check("R1 drive enable", v, 32'h0);
    rd(3'd1, v); check("R1 input enable", v, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R1 output value", v, 32'h0);
    rd(3'd3, v); check("R1 captured", v, 32'h0);
    rd(3'd4, v); check("R1 irq enable", v, 32'h0);
    rd(3'd5, v); check("R1 flags", v, 32'h0);
    rd(3'd6, v); check("R1 config", v, 32'h0);
    check("R1 pin_oe", pin_oe_o, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    // R2 map, read-only capture, reserved address
    rd(3'd7, v); check("R2 reserved", v, 32'h0);
    wr(3'd2, 32'hA5A5_5A5A);
    check("R3 pin_out", pin_out_o, 32'hA5A5_5A5A);
    rd(3'd2, v); check("R2 output value readback", v, 32'hA5A5_5A5A);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R2 captured ignores write", v, 32'h0);
    wr(3'd6, 32'hFFFF_FFFC);
    rd(3'd6, v); check("R2 config width", v, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd0, 32'h0000_FF00);
    check("R3 pin_oe", pin_oe_o, 32'h0000_FF00);
    wr(3'd4, 32'h0000_00FF);
    rd(3'd4, v); check("R2 irq enable readback", v, 32'h0000_00FF);

    // R4 R5 R8 table walk
    foreach (VECS[i]) begin
      pin_in_i = VECS[i].pins;
      tick(4);
      rd(3'd3, v); check($sformatf("R4/R5 vec%0d captured", i), v, VECS[i].cap);
      rd(3'd5, v); check($sformatf("R8 vec%0d flags", i), v, VECS[i].flg);
      check($sformatf("R10 vec%0d irq", i), {31'h0, irq_o}, {31'h0, VECS[i].flg != 0});
      wr(3'd5, 32'hFFFF_FFFF);
    end

    // R5 falling clock edge
    wr(3'd6, 32'h2);
    pin_in_i = 32'h0000_0000;
    tick(4);
    rd(3'd3, v); check("R5 falling clock capture", v, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);

    // R6 strobe rising
    wr(3'd6, 32'h1);
    pin_in_i = 32'h1234_0056;
    tick(5);
    rd(3'd3, v); check("R6 no strobe no capture", v, 32'h0);
    strobe_i = 1'b1;
    tick(4);
    rd(3'd3, v); check("R6 strobe rise capture", v, 32'h1234_0056);
    pin_in_i = 32'h00CC_0011;
    tick(5);
    rd(3'd3, v); check("R6 hold while strobe high", v, 32'h1234_0056);
    strobe_i = 1'b0;
    tick(5);
    rd(3'd3, v); check("R6 strobe fall ignored", v, 32'h1234_0056);

    // R7 strobe falling
    wr(3'd6, 32'h3);
    strobe_i = 1'b1;
    tick(5);
    rd(3'd3, v); check("R7 strobe rise ignored", v, 32'h1234_0056);
    strobe_i = 1'b0;
    tick(4);
    rd(3'd3, v); check("R7 strobe fall capture", v, 32'h00CC_0011);

    // R9 set wins over clear on the same edge
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0);
    tick(4);
    wr(3'd5, 32'hFFFF_FFFF);
    pin_in_i = 32'h00CC_0010;
    tick(2);
    wr(3'd5, 32'h0000_0001);
    rd(3'd5, v); check("R9 set beats clear", v, 32'h0000_0001);
    wr(3'd5, 32'hFFFF_FFFF);
    pin_in_i = 32'h00CC_0013;
    tick(4);
    rd(3'd5, v); check("R9 two flags", v, 32'h0000_0003);
    wr(3'd5, 32'h0000_0002);
    rd(3'd5, v); check("R9 partial clear", v, 32'h0000_0001);

    // R10 masking and R8 disabled line
    check("R10 irq on", {31'h0, irq_o}, 32'h1);
    wr(3'd4, 32'h0);
    check("R10 irq masked", {31'h0, irq_o}, 32'h0);
    pin_in_i = 32'h00CC_0017;
    tick(4);
    rd(3'd5, v); check("R8 disabled line no flag", v, 32'h0000_0001);
    wr(3'd4, 32'h0000_0001);
    check("R10 irq unmasked", {31'h0, irq_o}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule